// File: doc/BRIEF.md
# BCD Real-Time Clock with Field Adjust

This block keeps the time of day and a calendar date as packed binary-coded-decimal words. Each one-cycle pulse on the seconds strobe advances the time word through a full carry chain: seconds, then minutes, then hours, then day of week. The same pulse toggles an interrupt level, so software sees one edge per second. The date word does not move with the strobe. Software changes it either by a whole-word write or through the adjust path.

Software can set the clock in two ways. It can write a whole time or date word. It can also step one field by one unit with a two-write handshake: the first write arms the path and the second commits the step. A committed step wraps only its own field and never carries into a neighbour. Three mode bits select the field that steps. A freeze bit stops the automatic count but leaves the interrupt toggling.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time word reads 0x01000000, the date word reads 0x19990101, mode and control read 0, and `rtc_irq` is 0.
- R2: `bus_addr` 2 and 3 select the time and date words, which a write replaces whole and which read back unchanged. `bus_addr` 0 selects the mode register, which keeps `bus_wdata[3:0]` and reads 0 in bits 31:4. `bus_addr` 1 reads the armed flag in bit 0.
- R3: The time word packs seconds in [7:0], minutes in [15:8], hours 00 to 23 in [23:16] and day of week 1 to 7 in [27:24]. With mode bit 0 clear, each `sec_tick` pulse increments the seconds with BCD carry into minutes, then hours, then day of week. Hours wrap from 23 to 00, day of week wraps from 7 to 1, and the date word is left unchanged.
- R4: While mode bit 0 is 1, a `sec_tick` pulse leaves the time word unchanged.
- R5: `rtc_irq` inverts one cycle after every `sec_tick` pulse, whatever mode bit 0 holds, and holds its value otherwise.
- R6: A write of exactly 1 to control while disarmed sets the armed flag and changes nothing else. A write of exactly 1 while armed commits one adjust step and clears the flag. A control write of any other value leaves the flag unchanged in either state.
- R7: Mode bits [3:1] select the adjust field. Codes 0, 1 and 2 step seconds, minutes and hours: seconds and minutes wrap from 59 to 00, hours wrap from 23 to 00. Code 3 steps day of week, wrapping from 7 to 1. No other field of the time word changes.
- R8: The date word packs the day in [7:0], the month in [15:8] and the year in [31:16]. Adjust code 4 steps the day, wrapping from 31 to 01. Code 5 steps the month, wrapping from 12 to 01. Code 6 steps the low year byte, wrapping from 99 to 00. Code 7 changes neither word. No step carries into another field.
- R9: When a time or date write coincides with `sec_tick`, the written value is stored. When an adjust commit coincides with `sec_tick`, the stepped value of the targeted word is stored and the tick's advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle seconds strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rtc_irq | output | 1 | Interrupt level, inverted on every tick |

## Verification
Four properties are checked on every cycle:
- the interrupt inverting on each strobe and holding otherwise;
- a frozen time word staying put under a strobe;
- the date word staying still without a write or commit, and a time write winning over a coinciding strobe;
- the adjust path's own rules: a commit always disarms, arming needs a write of 1, a seconds step never disturbs the upper fields, and a day step never yields day 00.

Only the bench scenarios can show the carry chain's exact values across every rollover boundary and each field's wrap value. The same holds for a commit beating a coinciding strobe.

// File: rtl/bcd_rtc_pkg.sv
`timescale 1ns/1ps
package bcd_rtc_pkg;
  localparam int WORD_W = 32;
  localparam int MODE_W = 4;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE = 2'd0, RA_CTRL = 2'd1, RA_TIME = 2'd2, RA_DATE = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    FLD_SEC, FLD_MIN, FLD_HOUR, FLD_WDAY, FLD_DAY, FLD_MONTH, FLD_YEARLO, FLD_NONE
  } adj_field_e;

  // Step one BCD byte; at or above top it returns floor.
  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] floor_v);
    logic [3:0] hi;
    hi = v[7:4] + 4'd1;
    if (v >= top) return floor_v;
    else if (v[3:0] >= 4'd9) return {hi, 4'd0};
    else return v + 8'd1;
  endfunction

  function automatic logic [3:0] wday_next(input logic [3:0] d);
    if (d >= 4'd7) return 4'd1;
    else return d + 4'd1;
  endfunction

  // Full carry chain for one second.
  function automatic logic [WORD_W-1:0] tick_time(input logic [WORD_W-1:0] t);
    logic [WORD_W-1:0] n;
    n = t;
    n[7:0] = bcd_next(t[7:0], 8'h59, 8'h00);
    if (t[7:0] >= 8'h59) begin
      n[15:8] = bcd_next(t[15:8], 8'h59, 8'h00);
      if (t[15:8] >= 8'h59) begin
        n[23:16] = bcd_next(t[23:16], 8'h23, 8'h00);
        if (t[23:16] >= 8'h23) n[27:24] = wday_next(t[27:24]);
      end
    end
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] adjust_time(input adj_field_e f,
                                                    input logic [WORD_W-1:0] t);
    logic [WORD_W-1:0] n;
    n = t;
    case (f)
      FLD_SEC:  n[7:0]   = bcd_next(t[7:0], 8'h59, 8'h00);
      FLD_MIN:  n[15:8]  = bcd_next(t[15:8], 8'h59, 8'h00);
      FLD_HOUR: n[23:16] = bcd_next(t[23:16], 8'h23, 8'h00);
      FLD_WDAY: n[27:24] = wday_next(t[27:24]);
      default:  n = t;
    endcase
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] adjust_date(input adj_field_e f,
                                                    input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] n;
    n = d;
    case (f)
      FLD_DAY:    n[7:0]   = bcd_next(d[7:0], 8'h31, 8'h01);
      FLD_MONTH:  n[15:8]  = bcd_next(d[15:8], 8'h12, 8'h01);
      FLD_YEARLO: n[23:16] = bcd_next(d[23:16], 8'h99, 8'h00);
      default:    n = d;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/rtc_adjust_ctl.sv
`timescale 1ns/1ps
module rtc_adjust_ctl
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [WORD_W-1:0] ctrl_wdata,
  output logic              armed,
  output logic              commit
);
  logic key_one;
  assign key_one = (ctrl_wdata == WORD_W'(1));
  assign commit  = ctrl_wr && key_one && armed;

  always_ff @(posedge clk) begin
    if (!rst_n)                 armed <= 1'b0;
    else if (ctrl_wr && key_one) armed <= ~armed;
  end

  // R6
  commit_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !armed);
  // R6
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(ctrl_wr && ctrl_wdata == WORD_W'(1)));
endmodule

// File: rtl/rtc_time_keeper.sv
`timescale 1ns/1ps
module rtc_time_keeper
  import bcd_rtc_pkg::*;
#(
  parameter logic [WORD_W-1:0] TIME_INIT = 32'h0100_0000,
  parameter logic [WORD_W-1:0] DATE_INIT = 32'h1999_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              time_wr,
  input  logic              date_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              commit,
  input  adj_field_e        field,
  output logic [WORD_W-1:0] time_q,
  output logic [WORD_W-1:0] date_q
);
  logic adj_time, adj_date;
  assign adj_time = commit && (field <= FLD_WDAY);
  assign adj_date = commit && (field == FLD_DAY || field == FLD_MONTH || field == FLD_YEARLO);

  always_ff @(posedge clk) begin
    if (!rst_n)        time_q <= TIME_INIT;
    else if (time_wr)  time_q <= wdata;
    else if (adj_time) time_q <= adjust_time(field, time_q);
    else if (advance)  time_q <= tick_time(time_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        date_q <= DATE_INIT;
    else if (date_wr)  date_q <= wdata;
    else if (adj_date) date_q <= adjust_date(field, date_q);
  end

  // R9
  time_wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> time_q == $past(wdata));
  // R3
  date_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !date_wr && !commit |=> $stable(date_q));
  // R7
  sec_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && field == FLD_SEC |=> time_q[31:8] == $past(time_q[31:8]));
  // R8
  day_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && field == FLD_DAY |=> date_q[7:0] != 8'h00);
endmodule

// File: rtl/bcd_rtc.sv
`timescale 1ns/1ps
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter logic [31:0] TIME_INIT = 32'h0100_0000,
  parameter logic [31:0] DATE_INIT = 32'h1999_0101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rtc_irq
);
  logic [MODE_W-1:0] mode_q;
  logic              freeze, advance, armed, commit;
  logic              mode_wr, ctrl_wr, time_wr, date_wr;
  logic [WORD_W-1:0] time_q, date_q;
  adj_field_e        field;

  assign mode_wr = bus_wr && bus_addr == RA_MODE;
  assign ctrl_wr = bus_wr && bus_addr == RA_CTRL;
  assign time_wr = bus_wr && bus_addr == RA_TIME;
  assign date_wr = bus_wr && bus_addr == RA_DATE;
  assign freeze  = mode_q[0];
  assign field   = adj_field_e'(mode_q[3:1]);
  assign advance = sec_tick && !freeze;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= bus_wdata[MODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rtc_irq <= 1'b0;
    else if (sec_tick) rtc_irq <= ~rtc_irq;
  end

  rtc_adjust_ctl u_adj (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(bus_wdata),
    .armed(armed), .commit(commit)
  );

  rtc_time_keeper #(.TIME_INIT(TIME_INIT), .DATE_INIT(DATE_INIT)) u_keep (
    .clk(clk), .rst_n(rst_n), .advance(advance), .time_wr(time_wr),
    .date_wr(date_wr), .wdata(bus_wdata), .commit(commit), .field(field),
    .time_q(time_q), .date_q(date_q)
  );

  always_comb begin
    case (bus_addr)
      RA_MODE: bus_rdata = {{(WORD_W-MODE_W){1'b0}}, mode_q};
      RA_CTRL: bus_rdata = {{(WORD_W-1){1'b0}}, armed};
      RA_TIME: bus_rdata = time_q;
      default: bus_rdata = date_q;
    endcase
  end

  // R5
  irq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> rtc_irq != $past(rtc_irq));
  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(rtc_irq));
  // R4
  frozen_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && freeze && !time_wr && !commit |=> $stable(time_q));
endmodule

// File: tb/bcd_rtc_bench.sv
`timescale 1ns/1ps
module bcd_rtc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {time before tick, time after tick}
  localparam logic [63:0] TICK_VEC [NVEC] = '{
    {32'h0100_0000, 32'h0100_0001},
    {32'h0100_0009, 32'h0100_0010},
    {32'h0100_0059, 32'h0100_0100},
    {32'h0100_0959, 32'h0100_1000},
    {32'h0100_5959, 32'h0101_0000},
    {32'h0109_5959, 32'h0110_0000},
    {32'h0123_5959, 32'h0200_0000},
    {32'h0723_5959, 32'h0100_0000},
    {32'h0312_4530, 32'h0312_4531},
    {32'h0519_5959, 32'h0520_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata, rv;
  logic rtc_irq, exp_irq = 1'b0, done = 1'b0;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc u_bcd_rtc (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_irq(rtc_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; exp_irq = ~exp_irq;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic do_adj(input logic [2:0] f);
    do_wr(2'd0, {28'd0, f, 1'b0});
    do_wr(2'd1, 32'd1);
    do_wr(2'd1, 32'd1);
  endtask

  task automatic adj_time_case(input string tag, input logic [2:0] f,
                               input logic [31:0] t0, input logic [31:0] t1);
    do_wr(2'd2, t0); do_adj(f); do_rd(2'd2, rv); chk(tag, rv, t1);
  endtask

  task automatic adj_date_case(input string tag, input logic [2:0] f,
                               input logic [31:0] d0, input logic [31:0] d1);
    do_wr(2'd3, d0); do_adj(f); do_rd(2'd3, rv); chk(tag, rv, d1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    do_rd(2'd2, rv); chk("R1 time", rv, 32'h0100_0000);
    do_rd(2'd3, rv); chk("R1 date", rv, 32'h1999_0101);
    do_rd(2'd0, rv); chk("R1 mode", rv, 32'h0);
    do_rd(2'd1, rv); chk("R1 ctrl", rv, 32'h0);
    chk("R1 irq", {31'd0, rtc_irq}, 32'h0);

    // R3 carry chain vectors
    for (int i = 0; i < NVEC; i++) begin
      do_wr(2'd2, TICK_VEC[i][63:32]);
      do_tick();
      do_rd(2'd2, rv); chk("R3 tick", rv, TICK_VEC[i][31:0]);
      chk("R5 irq", {31'd0, rtc_irq}, {31'd0, exp_irq});
    end
    do_rd(2'd3, rv); chk("R3 date untouched", rv, 32'h1999_0101);

    // R2 register access
    do_wr(2'd3, 32'h2024_0615); do_rd(2'd3, rv); chk("R2 date rw", rv, 32'h2024_0615);
    do_wr(2'd0, 32'hFFFF_FFF0); do_rd(2'd0, rv); chk("R2 mode bits", rv, 32'h0);
    do_wr(2'd0, 32'h0000_001B); do_rd(2'd0, rv); chk("R2 mode low", rv, 32'hB);

    // R4 freeze, R5 irq still toggles
    do_wr(2'd0, 32'h1);
    do_wr(2'd2, 32'h0100_0005);
    do_tick();
    do_rd(2'd2, rv); chk("R4 frozen", rv, 32'h0100_0005);
    chk("R5 irq frozen", {31'd0, rtc_irq}, {31'd0, exp_irq});
    do_wr(2'd0, 32'h0);

    // R6 handshake guard
    do_wr(2'd2, 32'h0100_0010);
    do_wr(2'd1, 32'd2); do_rd(2'd1, rv); chk("R6 other disarmed", rv, 32'h0);
    do_wr(2'd1, 32'd1); do_rd(2'd1, rv); chk("R6 armed", rv, 32'h1);
    do_rd(2'd2, rv); chk("R6 arm no step", rv, 32'h0100_0010);
    do_wr(2'd1, 32'd5); do_rd(2'd1, rv); chk("R6 other armed", rv, 32'h1);
    do_rd(2'd2, rv); chk("R6 other no step", rv, 32'h0100_0010);
    do_wr(2'd1, 32'd1); do_rd(2'd1, rv); chk("R6 commit disarms", rv, 32'h0);
    do_rd(2'd2, rv); chk("R6 commit step", rv, 32'h0100_0011);

    // R7 time field adjust
    adj_time_case("R7 sec wrap", 3'd0, 32'h0100_0059, 32'h0100_0000);
    adj_time_case("R7 min wrap", 3'd1, 32'h0100_5900, 32'h0100_0000);
    adj_time_case("R7 hour wrap", 3'd2, 32'h0123_0000, 32'h0100_0000);
    adj_time_case("R7 hour digit", 3'd2, 32'h0109_1234, 32'h0110_1234);
    adj_time_case("R7 wday wrap", 3'd3, 32'h0700_0000, 32'h0100_0000);

    // R8 date field adjust
    adj_date_case("R8 day wrap", 3'd4, 32'h1999_0131, 32'h1999_0101);
    adj_date_case("R8 day digit", 3'd4, 32'h1999_0109, 32'h1999_0110);
    adj_date_case("R8 month wrap", 3'd5, 32'h1999_1231, 32'h1999_0131);
    adj_date_case("R8 year wrap", 3'd6, 32'h1999_1231, 32'h1900_1231);
    do_wr(2'd2, 32'h0312_3456);
    adj_date_case("R8 code7 date", 3'd7, 32'h2001_0203, 32'h2001_0203);
    do_rd(2'd2, rv); chk("R8 code7 time", rv, 32'h0312_3456);

    // R9 write versus tick in one cycle
    do_wr(2'd0, 32'h0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h0222_2222; sec_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; sec_tick = 1'b0; exp_irq = ~exp_irq;
    do_rd(2'd2, rv); chk("R9 write wins", rv, 32'h0222_2222);
    chk("R5 irq coincide", {31'd0, rtc_irq}, {31'd0, exp_irq});

    // R9 commit versus tick: minutes field
    do_wr(2'd2, 32'h0100_0059);
    do_wr(2'd0, 32'h2);
    do_wr(2'd1, 32'd1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'd1; sec_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; sec_tick = 1'b0; exp_irq = ~exp_irq;
    do_rd(2'd2, rv); chk("R9 commit wins", rv, 32'h0100_0159);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule